// File: doc/BRIEF.md
# Shared Program Flash Write/Engine Arbiter

This block decides who owns a shared program flash. A periodic compute engine reads its code from that flash once per frame, and a processor writes single bytes into it. On each frame-start pulse, the engine either begins a code pass or loses that frame to a write that is still running. A processor write either starts a fixed-length busy interval or is thrown away because the engine holds the flash.

Each kind of conflict sets its own sticky interrupt flag. The processor clears a flag by writing 1 to its clear bit. A one-cycle pulse marks the moment the engine releases the flash, which is when firmware should start its writes.

The block also builds the engine's instruction word address. It joins a 5-bit relocatable base register with the engine's 10-bit code offset. The base register can be changed only while the engine is disabled. For each accepted write, the block reports the latched byte address and data, and the 512-byte erase page that holds the address.

Top module: `flash_engine_arbiter`

## Requirements
- R1: A write request seen while `eng_busy_o` is high, or in the same cycle that a pass starts, is not performed: `flash_busy_o` stays low. `irq_col0_o` is high from the next cycle.
- R2: An accepted write makes `flash_busy_o` high for exactly WR_CYCLES cycles, starting the cycle after the request. `flash_wr_addr_o` and `flash_wr_data_o` hold the request's address and data from that cycle on.
- R3: A frame start with the engine enabled and idle, while `flash_busy_o` is high, starts no pass: `eng_busy_o` stays low. `irq_col1_o` is high from the next cycle, and the write runs to its full length.
- R4: A frame start with the engine enabled, idle and the flash not busy sets `eng_busy_o` from the next cycle. `eng_busy_o` stays high until the cycle after `eng_done_i` is seen. Frame starts during a pass are ignored.
- R5: `irq_busy_fall_o` is high for exactly one cycle: the first cycle in which `eng_busy_o` reads low after having been high.
- R6: `eng_iaddr_o` equals 1024 × `loc_o` + `eng_ofs_i`.
- R7: A write to the location register (`loc_we_i`) takes effect on the next cycle only while `eng_en_i` is low. While `eng_en_i` is high it is ignored.
- R8: `irq_col0_o` and `irq_col1_o` stay set until `irq_clr_i` bit 0 or bit 1, respectively, is 1. If a set and a clear of the same flag happen in the same cycle, the set wins.
- R9: With `eng_en_i` low, `eng_busy_o` is low from the next cycle, and frame starts neither start a pass nor set `irq_col1_o`.
- R10: A write request made while `flash_busy_o` is high is ignored. It changes neither the latched address/data nor the busy length, and it sets no flag.
- R11: `flash_wr_page_o` equals `flash_wr_addr_o` divided by 512.
- R12: After reset, every output is zero, including `loc_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| eng_en_i | input | 1 | Engine enable |
| frame_start_i | input | 1 | Frame-start pulse |
| eng_done_i | input | 1 | Engine finished its code pass |
| eng_ofs_i | input | 10 | Engine instruction offset |
| eng_iaddr_o | output | 15 | Engine instruction word address |
| loc_we_i | input | 1 | Location register write strobe |
| loc_wdata_i | input | 5 | Location register write data |
| loc_o | output | 5 | Location register value |
| wr_req_i | input | 1 | Processor flash byte write request |
| wr_addr_i | input | 13 | Write byte address |
| wr_data_i | input | 8 | Write data byte |
| flash_busy_o | output | 1 | Write interval in progress |
| flash_wr_addr_o | output | 13 | Latched write address |
| flash_wr_data_o | output | 8 | Latched write data |
| flash_wr_page_o | output | 4 | Erase page of latched address |
| eng_busy_o | output | 1 | Engine pass in progress |
| irq_busy_fall_o | output | 1 | Engine released the flash (pulse) |
| irq_col0_o | output | 1 | Sticky flag: write dropped |
| irq_col1_o | output | 1 | Sticky flag: pass skipped |
| irq_clr_i | input | 2 | Write-1-to-clear: bit 0 col0, bit 1 col1 |

## Verification
The assertions assume that all inputs are known after reset and change only between clock edges. They also assume that `eng_done_i` has meaning only while a pass is running. The RTL ignores it otherwise, so the properties never depend on it outside a pass.

The bench changes inputs a short time after each rising edge. Its directed sequences raise `eng_done_i` only during a pass. Its random phase also pulses `eng_done_i`, frame starts, writes and clears freely, including in the same cycle. This keeps the tie cases and the last-busy-cycle cases inside the behaviour described above.

// File: rtl/flash_arb_pkg.sv
package flash_arb_pkg;
  localparam int NUM_COL = 2;
  typedef enum int {
    COL_WR_DROP   = 0,
    COL_PASS_SKIP = 1
  } col_e;
endpackage

// File: rtl/irq_sticky.sv
module irq_sticky (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      flag_o <= 1'b0;
    else if (set_i)   flag_o <= 1'b1;
    else if (clr_i)   flag_o <= 1'b0;
  end

  assert_sticky_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_o && !clr_i |=> flag_o);
  assert_set_wins_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> flag_o);
endmodule

// File: rtl/frame_sched.sv
module frame_sched (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic frame_start_i,
  input  logic done_i,
  input  logic wr_busy_i,
  output logic busy_o,
  output logic pass_start_o,
  output logic skip_o,
  output logic fall_o
);
  logic busy_q, prev_q;

  assign pass_start_o = frame_start_i & en_i & ~busy_q & ~wr_busy_i;
  assign skip_o       = frame_start_i & en_i & ~busy_q &  wr_busy_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      busy_q <= en_i & (pass_start_o | (busy_q & ~done_i));
      prev_q <= busy_q;
    end
  end

  assign busy_o = busy_q;
  assign fall_o = prev_q & ~busy_q;

  assert_skip_no_pass_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_i && !busy_q && wr_busy_i |=> !busy_q);
  assert_pass_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && en_i && !done_i |=> busy_q);
  assert_fall_single_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_o |=> !fall_o);
  assert_disable_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !busy_q);
  assert_excl_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(busy_q && wr_busy_i));
endmodule

// File: rtl/flash_wr_ctrl.sv
module flash_wr_ctrl #(
  parameter int BA_W       = 13,
  parameter int WR_CYCLES  = 8,
  parameter int PAGE_BYTES = 512,
  localparam int PG_SH = $clog2(PAGE_BYTES),
  localparam int PG_W  = BA_W - PG_SH
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_req_i,
  input  logic [BA_W-1:0] wr_addr_i,
  input  logic [7:0]      wr_data_i,
  input  logic            eng_busy_i,
  input  logic            pass_start_i,
  output logic            busy_o,
  output logic [BA_W-1:0] addr_o,
  output logic [7:0]      data_o,
  output logic [PG_W-1:0] page_o,
  output logic            drop_o
);
  localparam int CNT_W = $clog2(WR_CYCLES + 1);

  logic [CNT_W-1:0] cnt_q;
  logic             accept;

  assign busy_o = (cnt_q != '0);
  // engine wins a same-cycle tie
  assign accept = wr_req_i & ~busy_o & ~eng_busy_i & ~pass_start_i;
  assign drop_o = wr_req_i & (eng_busy_i | pass_start_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      addr_o <= '0;
      data_o <= '0;
    end else begin
      if (accept) begin
        cnt_q  <= CNT_W'(WR_CYCLES);
        addr_o <= wr_addr_i;
        data_o <= wr_data_i;
      end else if (busy_o) begin
        cnt_q  <= cnt_q - 1'b1;
      end
    end
  end

  assign page_o = addr_o[BA_W-1:PG_SH];

  // run-length checker
  logic [CNT_W:0] run_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     run_q <= '0;
    else if (busy_o) run_q <= run_q + 1'b1;
    else             run_q <= '0;
  end

  assert_wr_length_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> run_q == (CNT_W+1)'(WR_CYCLES));
  assert_drop_no_write_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_req_i && eng_busy_i |=> !busy_o);
  assert_no_restart_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && wr_req_i |=> $stable(addr_o) && $stable(data_o));
endmodule

// File: rtl/flash_engine_arbiter.sv
module flash_engine_arbiter
  import flash_arb_pkg::*;
#(
  parameter int LOC_W      = 5,
  parameter int OFS_W      = 10,
  parameter int BA_W       = 13,
  parameter int WR_CYCLES  = 8,
  parameter int PAGE_BYTES = 512,
  localparam int IA_W = LOC_W + OFS_W,
  localparam int PG_W = BA_W - $clog2(PAGE_BYTES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             eng_en_i,
  input  logic             frame_start_i,
  input  logic             eng_done_i,
  input  logic [OFS_W-1:0] eng_ofs_i,
  output logic [IA_W-1:0]  eng_iaddr_o,
  input  logic             loc_we_i,
  input  logic [LOC_W-1:0] loc_wdata_i,
  output logic [LOC_W-1:0] loc_o,
  input  logic             wr_req_i,
  input  logic [BA_W-1:0]  wr_addr_i,
  input  logic [7:0]       wr_data_i,
  output logic             flash_busy_o,
  output logic [BA_W-1:0]  flash_wr_addr_o,
  output logic [7:0]       flash_wr_data_o,
  output logic [PG_W-1:0]  flash_wr_page_o,
  output logic             eng_busy_o,
  output logic             irq_busy_fall_o,
  output logic             irq_col0_o,
  output logic             irq_col1_o,
  input  logic [1:0]       irq_clr_i
);
  logic               pass_start, skip, drop;
  logic [NUM_COL-1:0] col_set, col_flag;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    loc_o <= '0;
    else if (loc_we_i && !eng_en_i) loc_o <= loc_wdata_i;
  end

  assign eng_iaddr_o = {loc_o, eng_ofs_i};

  frame_sched i_sched (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .en_i         (eng_en_i),
    .frame_start_i(frame_start_i),
    .done_i       (eng_done_i),
    .wr_busy_i    (flash_busy_o),
    .busy_o       (eng_busy_o),
    .pass_start_o (pass_start),
    .skip_o       (skip),
    .fall_o       (irq_busy_fall_o)
  );

  flash_wr_ctrl #(
    .BA_W      (BA_W),
    .WR_CYCLES (WR_CYCLES),
    .PAGE_BYTES(PAGE_BYTES)
  ) i_wr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_req_i    (wr_req_i),
    .wr_addr_i   (wr_addr_i),
    .wr_data_i   (wr_data_i),
    .eng_busy_i  (eng_busy_o),
    .pass_start_i(pass_start),
    .busy_o      (flash_busy_o),
    .addr_o      (flash_wr_addr_o),
    .data_o      (flash_wr_data_o),
    .page_o      (flash_wr_page_o),
    .drop_o      (drop)
  );

  assign col_set[COL_WR_DROP]   = drop;
  assign col_set[COL_PASS_SKIP] = skip;

  for (genvar g = 0; g < NUM_COL; g++) begin : g_col
    irq_sticky i_flag (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .set_i (col_set[g]),
      .clr_i (irq_clr_i[g]),
      .flag_o(col_flag[g])
    );
  end

  assign irq_col0_o = col_flag[COL_WR_DROP];
  assign irq_col1_o = col_flag[COL_PASS_SKIP];

  assert_col0_on_drop_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_req_i && eng_busy_o |=> irq_col0_o);
  assert_col1_on_skip_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_i && eng_en_i && !eng_busy_o && flash_busy_o |=> irq_col1_o && flash_busy_o == ($past(flash_busy_o) && !$fell(flash_busy_o)));
  assert_loc_locked_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_en_i |=> $stable(loc_o));
  assert_no_skip_disabled_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !eng_en_i && !irq_col1_o |=> !irq_col1_o);
endmodule

// File: tb/test_flash_engine_arbiter.sv
module test_flash_engine_arbiter;
  localparam int WR = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic en = 0, fs = 0, done = 0, lwe = 0, wr = 0;
  logic [9:0]  ofs = '0;
  logic [4:0]  ldat = '0;
  logic [12:0] waddr = '0;
  logic [7:0]  wdat = '0;
  logic [1:0]  clr = '0;

  logic [14:0] iaddr;
  logic [4:0]  loc;
  logic        fbusy, ebusy, fall, c0, c1;
  logic [12:0] faddr;
  logic [7:0]  fdat;
  logic [3:0]  fpage;

  int checks = 0, fails = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  flash_engine_arbiter #(.WR_CYCLES(WR)) i_flash_engine_arbiter (
    .clk_i(clk), .rst_ni(rst_n), .eng_en_i(en), .frame_start_i(fs),
    .eng_done_i(done), .eng_ofs_i(ofs), .eng_iaddr_o(iaddr),
    .loc_we_i(lwe), .loc_wdata_i(ldat), .loc_o(loc),
    .wr_req_i(wr), .wr_addr_i(waddr), .wr_data_i(wdat),
    .flash_busy_o(fbusy), .flash_wr_addr_o(faddr), .flash_wr_data_o(fdat),
    .flash_wr_page_o(fpage), .eng_busy_o(ebusy), .irq_busy_fall_o(fall),
    .irq_col0_o(c0), .irq_col1_o(c1), .irq_clr_i(clr)
  );

  // behavioural reference
  int m_busy, m_prev, m_rem, m_loc, m_c0, m_c1, m_addr, m_data;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 0; m_prev = 0; m_rem = 0; m_loc = 0;
      m_c0 = 0; m_c1 = 0; m_addr = 0; m_data = 0;
    end else begin
      bit start, skipf, take, dropf;
      start = fs && en && m_busy == 0 && m_rem == 0;
      skipf = fs && en && m_busy == 0 && m_rem != 0;
      dropf = wr && (m_busy != 0 || start);
      take  = wr && !dropf && m_rem == 0;
      m_prev = m_busy;
      if (!en) m_busy = 0;
      else if (start) m_busy = 1;
      else if (done) m_busy = 0;
      if (take) begin m_rem = WR; m_addr = waddr; m_data = wdat; end
      else if (m_rem > 0) m_rem--;
      if (dropf) m_c0 = 1; else if (clr[0]) m_c0 = 0;
      if (skipf) m_c1 = 1; else if (clr[1]) m_c1 = 0;
      if (lwe && !en) m_loc = ldat;
    end
  end

  task automatic cmp(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    cmp("R4 eng_busy", ebusy, m_busy);
    cmp("R2 flash_busy", fbusy, m_rem != 0);
    cmp("R2 wr_addr", faddr, m_addr);
    cmp("R2 wr_data", fdat, m_data);
    cmp("R11 page", fpage, m_addr / 512);
    cmp("R1 col0", c0, m_c0);
    cmp("R3 col1", c1, m_c1);
    cmp("R5 busy_fall", fall, m_prev != 0 && m_busy == 0);
    cmp("R7 loc", loc, m_loc);
    cmp("R6 iaddr", iaddr, m_loc * 1024 + ofs);
  end

  task automatic cyc(int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic frame();
    fs = 1; cyc(1); fs = 0;
  endtask

  task automatic wreq(int a, int d);
    wr = 1; waddr = 13'(a); wdat = 8'(d); cyc(1); wr = 0;
  endtask

  task automatic finish_pass();
    done = 1; cyc(1); done = 0;
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    cmp("R12 reset eng_busy", ebusy, 0);
    cmp("R12 reset flash_busy", fbusy, 0);
    cmp("R12 reset irqs", {c0, c1, fall}, 0);
    cmp("R12 reset loc", loc, 0);
    cmp("R12 reset wr_addr", faddr, 0);
    rst_n = 1;
    cyc(1);

    // R7 / R6: location while disabled
    ofs = 10'd3; ldat = 5'd5; lwe = 1; cyc(1); lwe = 0;
    cmp("R6 iaddr base 5", iaddr, 5 * 1024 + 3);
    en = 1; ldat = 5'd9; lwe = 1; cyc(1); lwe = 0;
    cmp("R7 loc locked when enabled", loc, 5);
    en = 0; ldat = 5'd31; lwe = 1; cyc(1); lwe = 0; en = 1;
    ofs = 10'd1023; cyc(1);
    cmp("R6 iaddr max", iaddr, 31 * 1024 + 1023);

    // R4/R5: plain pass
    frame();
    cmp("R4 pass started", ebusy, 1);
    frame(); cyc(2);
    cmp("R4 frame during pass ignored", ebusy, 1);
    finish_pass();
    cmp("R5 fall pulse", fall, 1);
    cyc(1);
    cmp("R5 fall single", fall, 0);

    // R2/R11 write in window, R3 skip
    wreq(13'h3FF, 8'hAA);
    cmp("R2 write busy", fbusy, 1);
    cmp("R11 page of 0x3FF", fpage, 1);
    cyc(2);
    frame();
    cmp("R3 pass skipped", ebusy, 0);
    cmp("R3 col1 set", c1, 1);
    cyc(WR);
    frame();
    cmp("R4 resume next frame", ebusy, 1);
    // R1 write during pass
    wreq(13'h200, 8'h11);
    cmp("R1 write dropped", fbusy, 0);
    cmp("R1 col0 set", c0, 1);
    finish_pass();

    // R8 clears
    clr = 2'b01; cyc(1); clr = 0;
    cmp("R8 col0 cleared", c0, 0);
    cmp("R8 col1 kept", c1, 1);
    clr = 2'b10; cyc(1); clr = 0;
    cmp("R8 col1 cleared", c1, 0);

    // R1 same-cycle tie: engine wins
    fs = 1; wr = 1; waddr = 13'h123; cyc(1); fs = 0; wr = 0;
    cmp("R1 tie pass wins", ebusy, 1);
    cmp("R1 tie write dropped", fbusy, 0);
    cmp("R1 tie col0", c0, 1);
    finish_pass();

    // R3 frame on last busy cycle
    wreq(13'h1FF0, 8'h5C);
    cyc(WR - 1);
    frame();
    cmp("R3 skip on last busy cycle", ebusy, 0);
    cmp("R11 page of 0x1FF0", fpage, 15);
    frame();
    cmp("R4 start after write end", ebusy, 1);
    finish_pass();

    // R10 write while write busy
    wreq(13'h040, 8'h01);
    wreq(13'h800, 8'h02);
    cmp("R10 addr kept", faddr, 13'h040);
    cmp("R10 data kept", fdat, 8'h01);
    cyc(WR);
    cmp("R10 busy not extended", fbusy, 0);

    // R8 set beats clear
    clr = 2'b11; frame(); wr = 1; cyc(1); wr = 0; clr = 0;
    cmp("R8 set wins over clear", c0, 1);

    // R9 disable mid-pass
    en = 0; cyc(1);
    cmp("R9 disable ends pass", ebusy, 0);
    clr = 2'b11; cyc(1); clr = 0;
    wreq(13'h010, 8'h33);
    frame();
    cmp("R9 no skip while disabled", c1, 0);
    cmp("R9 no pass while disabled", ebusy, 0);
    en = 1; cyc(WR);

    // random mix
    for (int i = 0; i < 4000; i++) begin
      fs    = ($urandom % 12) == 0;
      wr    = ($urandom % 6) == 0;
      done  = ($urandom % 7) == 0;
      clr   = 2'(($urandom % 15 == 0) ? $urandom : 0);
      en    = ($urandom % 40) != 0;
      lwe   = ($urandom % 25) == 0;
      ldat  = 5'($urandom);
      ofs   = 10'($urandom);
      waddr = 13'($urandom);
      wdat  = 8'($urandom);
      cyc(1);
    end
    fs = 0; wr = 0; done = 0; clr = 0; lwe = 0;
    cyc(2);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule